// File: doc/BRIEF.md
# Eight-Level Interrupt Priority Resolver

This block arbitrates among eight interrupt request lines for one processor. It keeps three eight-bit registers: captured requests, mask bits and in-service bits. From these it decides whether an interrupt should be raised. When the processor acknowledges, the block picks the winning level, reports it as a 3-bit code and records it as in service. The in-service record then holds off equal and lower priorities until software retires it.

Software controls the block with short command words. There are three kinds: a whole-mask load, an end-of-interrupt and rotation word, and a special-mask word. Two static inputs choose between edge and level capture and turn automatic retirement on or off. The ranking is circular. A pointer names the level that currently has the highest priority, and the rotate commands move that pointer. After reset the pointer sits at level 0, so level 0 ranks first and level 7 ranks last.

A small state machine sequences the handshake with the processor:
- ST_IDLE moves to ST_PEND when an eligible request exists.
- ST_PEND falls back to ST_IDLE if the eligible request disappears.
- ST_PEND moves to ST_SERVE when an acknowledge arrives.
- ST_SERVE always returns to ST_IDLE on the next clock.

Top module: `prio_resolver`

## Requirements
- R1: While reset is low, and on the first cycle after it, the request, mask and in-service registers read zero, `int_out` and `lvl_valid` are low, and level 0 holds the highest priority.
- R2: With `level_mode`=0, a rising edge on `irq_in[n]` sets request bit n one clock later. The bit stays set after the input falls and is cleared when level n wins an acknowledge.
- R3: With `level_mode`=1, the request register copies `irq_in` each clock. An acknowledge that finds no eligible request is spurious: it reports level 7 and sets no in-service bit.
- R4: `cmd_kind`=0 loads all eight mask bits from `cmd_data[7:0]` in one write. A mask bit of 1 keeps that level from raising `int_out`; a 0 lets it through.
- R5: `int_out` rises on the second clock after an eligible request bit is set. An acknowledge sampled while `int_out` is high drops `int_out` on the next clock. On that same clock `lvl_valid` pulses for one cycle with the level on `lvl_out`.
- R6: On acknowledge, the winner is the eligible request with the best rank counted from the priority pointer. Its in-service bit is set and, in edge mode, its request bit is cleared.
- R7: With special masking off, a level is eligible only if it outranks every in-service level. A level equal to or below the best in-service level is held off.
- R8: `cmd_kind`=1 with bit5=1, bit6=0, bit7=0 is a non-specific end of interrupt. It clears the best-ranked in-service bit.
- R9: `cmd_kind`=1 with bit5=1, bit6=1, bit7=0 is a specific end of interrupt. It clears the in-service bit named by `cmd_data[2:0]`.
- R10: Bit7=1 adds rotation, which moves the pointer to one past a chosen level so that level becomes the lowest priority. With bit5=1, bit6=0 the chosen level is the retired one. With bit5=1, bit6=1 it is `cmd_data[2:0]`, which is also retired. With bit5=0, bit6=1 it is `cmd_data[2:0]`, and only the pointer moves.
- R11: `cmd_kind`=2 updates special masking only when bit1=1, setting the mode to bit0; with bit1=0 nothing changes. In special mask mode, in-service levels block no other level, and any unmasked request that is not in service may interrupt.
- R12: With `auto_eoi`=1, an acknowledge still reports and clears the request but sets no in-service bit.
- R13: An acknowledge while `int_out` is low changes no register and produces no `lvl_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | 8 | Interrupt request lines, bit n is level n |
| level_mode | input | 1 | 1 = level capture, 0 = rising-edge capture |
| auto_eoi | input | 1 | 1 = acknowledge sets no in-service bit |
| cmd_valid | input | 1 | Command word strobe |
| cmd_kind | input | 2 | 0 mask load, 1 end-of-interrupt/rotate, 2 special mask, 3 ignored |
| cmd_data | input | 8 | Command word payload |
| ack | input | 1 | Processor acknowledge |
| int_out | output | 1 | Interrupt request to the processor |
| lvl_valid | output | 1 | One-cycle pulse marking `lvl_out` valid |
| lvl_out | output | 3 | Level chosen by the last acknowledge |
| irr_out | output | 8 | Request register contents |
| imr_out | output | 8 | Mask register contents |
| isr_out | output | 8 | In-service register contents |

## Verification
The bench runs a behavioural model in parallel with the design. The model re-ranks all levels by arithmetic on the pointer, and the bench compares every output against it on every clock.

Directed sequences target the failure modes this block is most exposed to:
- A lower-priority request that arrives while a higher level is in service must stay blocked. A design without nesting would raise the interrupt early.
- Set-priority and rotating end-of-interrupt commands test the pointer. A design that keeps a fixed order, or puts the pointer on the retired level instead of one past it, would hand the acknowledge to the wrong level.
- A level-mode request that drops before the acknowledge must give the spurious code 7 with no in-service bit. A design that does not re-check at acknowledge would report a stale level.
- A special-mask word whose enable bit is clear must have no effect. A design that ignores the enable bit would let a blocked lower level through.

// File: rtl/pri_pkg.sv
package pri_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PEND  = 2'd1,
        ST_SERVE = 2'd2
    } res_state_t;

    typedef enum logic [1:0] {
        CK_MASK   = 2'd0,
        CK_EOI    = 2'd1,
        CK_SPMASK = 2'd2,
        CK_NONE   = 2'd3
    } cmd_kind_t;

    // bit positions inside the end-of-interrupt / rotate word
    localparam int unsigned EOI_BIT = 5;
    localparam int unsigned SL_BIT  = 6;
    localparam int unsigned ROT_BIT = 7;

    // bit positions inside the special-mask word
    localparam int unsigned SPM_VAL_BIT = 0;
    localparam int unsigned SPM_EN_BIT  = 1;

endpackage

// File: rtl/pri_req_capture.sv
module pri_req_capture #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         level_mode,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] irr_q
);

    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[g] <= 1'b0;
                irr_q[g]  <= 1'b0;
            end else begin
                prev_q[g] <= irq_in[g];
                if (level_mode) begin
                    irr_q[g] <= irq_in[g];
                end else begin
                    irr_q[g] <= (irr_q[g] & ~ack_clr[g]) | (irq_in[g] & ~prev_q[g]);
                end
            end
        end
    end

endmodule

// File: rtl/pri_rank_pick.sv
module pri_rank_pick #(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    input  logic [LW-1:0] base,
    output logic          found,
    output logic [LW-1:0] idx
);

    logic [LW-1:0] lv;

    // scan from the lowest rank upward so the best rank is written last
    always_comb begin
        found = 1'b0;
        idx   = '0;
        lv    = '0;
        for (int k = N - 1; k >= 0; k--) begin
            lv = base + k[LW-1:0];
            if (vec[lv]) begin
                found = 1'b1;
                idx   = lv;
            end
        end
    end

endmodule

// File: rtl/pri_cmd_decode.sv
module pri_cmd_decode
    import pri_pkg::*;
#(
    parameter int N  = 8,
    parameter int CW = 8,
    parameter int LW = $clog2(N)
) (
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_kind,
    input  logic [CW-1:0] cmd_data,
    input  logic          isr_found,
    input  logic [LW-1:0] isr_top,
    output logic          mask_we,
    output logic [N-1:0]  mask_val,
    output logic [N-1:0]  isr_clr,
    output logic          hp_we,
    output logic [LW-1:0] hp_val,
    output logic          smm_we,
    output logic          smm_val
);

    localparam logic [N-1:0] ONE_HOT0 = {{(N-1){1'b0}}, 1'b1};

    logic          f_rot, f_sl, f_eoi;
    logic [LW-1:0] f_lvl;
    logic          is_eoi_word;

    assign f_rot       = cmd_data[ROT_BIT];
    assign f_sl        = cmd_data[SL_BIT];
    assign f_eoi       = cmd_data[EOI_BIT];
    assign f_lvl       = cmd_data[LW-1:0];
    assign is_eoi_word = cmd_valid && (cmd_kind == CK_EOI);

    assign mask_we  = cmd_valid && (cmd_kind == CK_MASK);
    assign mask_val = cmd_data[N-1:0];

    assign smm_we  = cmd_valid && (cmd_kind == CK_SPMASK) && cmd_data[SPM_EN_BIT];
    assign smm_val = cmd_data[SPM_VAL_BIT];

    always_comb begin
        isr_clr = '0;
        hp_we   = 1'b0;
        hp_val  = '0;
        if (is_eoi_word) begin
            if (f_eoi && !f_sl) begin
                if (isr_found) begin
                    isr_clr = ONE_HOT0 << isr_top;
                    hp_we   = f_rot;
                    hp_val  = isr_top + LW'(1);
                end
            end else if (f_eoi && f_sl) begin
                isr_clr = ONE_HOT0 << f_lvl;
                hp_we   = f_rot;
                hp_val  = f_lvl + LW'(1);
            end else if (!f_eoi && f_sl && f_rot) begin
                hp_we  = 1'b1;
                hp_val = f_lvl + LW'(1);
            end
        end
    end

    logic unused_bits;
    assign unused_bits = ^cmd_data;

endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
    import pri_pkg::*;
#(
    parameter int N  = 8,
    parameter int CW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         irq_in,
    input  logic                 level_mode,
    input  logic                 auto_eoi,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_kind,
    input  logic [CW-1:0]        cmd_data,
    input  logic                 ack,
    output logic                 int_out,
    output logic                 lvl_valid,
    output logic [$clog2(N)-1:0] lvl_out,
    output logic [N-1:0]         irr_out,
    output logic [N-1:0]         imr_out,
    output logic [N-1:0]         isr_out
);

    localparam int LW = $clog2(N);
    localparam logic [LW-1:0] SPUR_LVL = LW'(N - 1);
    localparam logic [N-1:0]  ONE_HOT0 = {{(N-1){1'b0}}, 1'b1};

    res_state_t    state_q, state_d;
    logic [N-1:0]  irr_q, imr_q, isr_q;
    logic [LW-1:0] hp_q;
    logic          smm_q;
    logic [LW-1:0] lvl_q;

    // ranking
    logic          isr_found, win_found;
    logic [LW-1:0] isr_top, win_idx, isr_rank;
    logic [N-1:0]  allow, cand;
    logic          cand_any, take;
    logic [N-1:0]  win_hot, ack_clr, isr_set;

    // command decode
    logic          mask_we, hp_we, smm_we, smm_val;
    logic [N-1:0]  mask_val, isr_clr;
    logic [LW-1:0] hp_val;

    pri_req_capture #(.N(N)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_mode (level_mode),
        .irq_in     (irq_in),
        .ack_clr    (ack_clr),
        .irr_q      (irr_q)
    );

    pri_rank_pick #(.N(N), .LW(LW)) u_isr_pick (
        .vec   (isr_q),
        .base  (hp_q),
        .found (isr_found),
        .idx   (isr_top)
    );

    assign isr_rank = isr_top - hp_q;

    for (genvar g = 0; g < N; g++) begin : g_allow
        logic [LW-1:0] rk;
        assign rk = LW'(g) - hp_q;
        assign allow[g] = smm_q ? ~isr_q[g] : (~isr_found | (rk < isr_rank));
    end

    assign cand     = irr_q & ~imr_q & allow;
    assign cand_any = |cand;

    pri_rank_pick #(.N(N), .LW(LW)) u_win_pick (
        .vec   (cand),
        .base  (hp_q),
        .found (win_found),
        .idx   (win_idx)
    );

    pri_cmd_decode #(.N(N), .CW(CW), .LW(LW)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_kind  (cmd_kind),
        .cmd_data  (cmd_data),
        .isr_found (isr_found),
        .isr_top   (isr_top),
        .mask_we   (mask_we),
        .mask_val  (mask_val),
        .isr_clr   (isr_clr),
        .hp_we     (hp_we),
        .hp_val    (hp_val),
        .smm_we    (smm_we),
        .smm_val   (smm_val)
    );

    assign take    = (state_q == ST_PEND) && ack;
    assign win_hot = ONE_HOT0 << win_idx;
    assign ack_clr = (take && win_found) ? win_hot : '0;
    assign isr_set = (take && win_found && !auto_eoi) ? win_hot : '0;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cand_any) state_d = ST_PEND;
            ST_PEND: begin
                if (ack)            state_d = ST_SERVE;
                else if (!cand_any) state_d = ST_IDLE;
            end
            ST_SERVE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs from state
    always_comb begin
        int_out   = 1'b0;
        lvl_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_PEND:  int_out   = 1'b1;
            ST_SERVE: lvl_valid = 1'b1;
            default:  ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr_q <= '0;
            isr_q <= '0;
            hp_q  <= '0;
            smm_q <= 1'b0;
            lvl_q <= '0;
        end else begin
            if (mask_we) imr_q <= mask_val;
            isr_q <= (isr_q & ~isr_clr) | isr_set;
            if (hp_we)  hp_q  <= hp_val;
            if (smm_we) smm_q <= smm_val;
            if (take)   lvl_q <= win_found ? win_idx : SPUR_LVL;
        end
    end

    assign lvl_out = lvl_q;
    assign irr_out = irr_q;
    assign imr_out = imr_q;
    assign isr_out = isr_q;

endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
    parameter int N  = 8,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack,
    input logic          auto_eoi,
    input logic          cmd_valid,
    input logic [1:0]    cmd_kind,
    input logic [CW-1:0] cmd_data,
    input logic          int_out,
    input logic          lvl_valid,
    input logic [N-1:0]  imr,
    input logic [N-1:0]  isr,
    input logic          smm
);

    // R1: reset clears registers and outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (imr == '0 && isr == '0 && !int_out && !lvl_valid));

    // R5: acknowledge drops the interrupt and presents the level
    p_ack_handoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (int_out && ack) |=> (!int_out && lvl_valid));

    // R5: level strobe is a single cycle
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_valid |=> !lvl_valid);

    // R4: mask load takes all bits at once
    p_mask_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd0) |=> (imr == $past(cmd_data[N-1:0])));

    // R12: automatic retirement leaves in-service untouched
    p_aeoi_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_eoi && !cmd_valid) |=> $stable(isr));

    // R13: no acknowledge effect while the interrupt is low
    p_idle_ack_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_out && !cmd_valid) |=> $stable(isr));

    // R11: special mask changes only under its enable bit
    p_smm_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_kind == 2'd2 && cmd_data[1]) |=> $stable(smm));

    logic unused_chk;
    assign unused_chk = ^cmd_data;

endmodule

bind prio_resolver prio_resolver_chk #(.N(N), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .auto_eoi  (auto_eoi),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .cmd_data  (cmd_data),
    .int_out   (int_out),
    .lvl_valid (lvl_valid),
    .imr       (imr_q),
    .isr       (isr_q),
    .smm       (smm_q)
);

// File: tb/tb_prio_resolver.sv
`timescale 1ns/1ps
module tb_prio_resolver;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       level_mode = 1'b0;
    logic       auto_eoi = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_kind = '0;
    logic [7:0] cmd_data = '0;
    logic       ack = 1'b0;
    logic       int_out, lvl_valid;
    logic [2:0] lvl_out;
    logic [7:0] irr_out, imr_out, isr_out;

    int checks = 0;
    int bad = 0;
    bit fin = 0;
    bit run = 0;

    always #5 clk = ~clk;

    prio_resolver dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(level_mode),
        .auto_eoi(auto_eoi), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_data(cmd_data), .ack(ack), .int_out(int_out), .lvl_valid(lvl_valid),
        .lvl_out(lvl_out), .irr_out(irr_out), .imr_out(imr_out), .isr_out(isr_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    logic [7:0] m_irr, m_imr, m_isr, m_prev;
    int m_hp, m_st, m_lvl;
    bit m_smm;

    always @(posedge clk) begin
        int top_l, top_r, win, nst, rk;
        logic [7:0] cand, clr, setb, aclr;
        if (!rst_n) begin
            m_irr = 0; m_imr = 0; m_isr = 0; m_prev = 0;
            m_hp = 0; m_st = 0; m_lvl = 0; m_smm = 0;
        end else begin
            top_l = -1; top_r = 8;
            for (int r = 0; r < 8; r++)
                if (top_l < 0 && m_isr[(m_hp + r) % 8]) begin top_l = (m_hp + r) % 8; top_r = r; end
            for (int l = 0; l < 8; l++) begin
                rk = (l - m_hp + 8) % 8;
                cand[l] = m_irr[l] && !m_imr[l] && (m_smm ? !m_isr[l] : (top_l < 0 || rk < top_r));
            end
            win = -1;
            for (int r = 0; r < 8; r++)
                if (win < 0 && cand[(m_hp + r) % 8]) win = (m_hp + r) % 8;
            nst = m_st;
            if (m_st == 0) begin if (cand != 0) nst = 1; end
            else if (m_st == 1) begin if (ack) nst = 2; else if (cand == 0) nst = 0; end
            else nst = 0;
            clr = 0; setb = 0; aclr = 0;
            if (cmd_valid && cmd_kind == 2'd1) begin
                if (cmd_data[5] && !cmd_data[6]) begin
                    if (top_l >= 0) begin
                        clr[top_l] = 1'b1;
                        if (cmd_data[7]) m_hp = (top_l + 1) % 8;
                    end
                end else if (cmd_data[5] && cmd_data[6]) begin
                    clr[cmd_data[2:0]] = 1'b1;
                    if (cmd_data[7]) m_hp = (cmd_data[2:0] + 1) % 8;
                end else if (cmd_data[6] && cmd_data[7]) begin
                    m_hp = (cmd_data[2:0] + 1) % 8;
                end
            end
            if (m_st == 1 && ack) begin
                if (win >= 0) begin
                    m_lvl = win; aclr[win] = 1'b1;
                    if (!auto_eoi) setb[win] = 1'b1;
                end else m_lvl = 7;
            end
            m_isr = (m_isr & ~clr) | setb;
            if (cmd_valid && cmd_kind == 2'd0) m_imr = cmd_data;
            if (cmd_valid && cmd_kind == 2'd2 && cmd_data[1]) m_smm = cmd_data[0];
            if (level_mode) m_irr = irq_in;
            else m_irr = (m_irr & ~aclr) | (irq_in & ~m_prev);
            m_prev = irq_in;
            m_st = nst;
        end
    end

    always @(negedge clk) begin
        if (run) begin
            chk("R5 int_out vs model", int_out, m_st == 1);
            chk("R5 lvl_valid vs model", lvl_valid, m_st == 2);
            if (m_st == 2) chk("R6 lvl_out vs model", lvl_out, m_lvl);
            chk("R2 irr vs model", irr_out, m_irr);
            chk("R4 imr vs model", imr_out, m_imr);
            chk("R6 isr vs model", isr_out, m_isr);
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc();
        @(posedge clk); #2;
    endtask

    task automatic send(input logic [1:0] k, input logic [7:0] d);
        cmd_valid = 1'b1; cmd_kind = k; cmd_data = d;
        cyc();
        cmd_valid = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1; cyc(); ack = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq_in = '0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
    endtask

    initial begin
        // phase A: edge capture, nesting, end-of-interrupt, rotation
        do_reset();
        run = 1;
        chk("R1 imr", imr_out, 8'h00);
        chk("R1 isr", isr_out, 8'h00);
        chk("R1 irr", irr_out, 8'h00);
        chk("R1 int", int_out, 1'b0);
        do_ack();
        chk("R13 isr after idle ack", isr_out, 8'h00);
        chk("R13 no strobe", lvl_valid, 1'b0);
        irq_in = 8'h20; cyc();
        chk("R2 edge latched", irr_out, 8'h20);
        chk("R5 int not yet", int_out, 1'b0);
        irq_in = 8'h00; cyc();
        chk("R2 held after fall", irr_out, 8'h20);
        chk("R5 int raised", int_out, 1'b1);
        do_ack();
        chk("R6 strobe", lvl_valid, 1'b1);
        chk("R6 level", lvl_out, 3'd5);
        chk("R6 isr set", isr_out, 8'h20);
        chk("R2 irr cleared", irr_out, 8'h00);
        chk("R5 int dropped", int_out, 1'b0);
        cyc();
        irq_in = 8'h80; cyc(); cyc(); cyc();
        chk("R7 lower blocked", int_out, 1'b0);
        irq_in = 8'h84; cyc(); cyc();
        chk("R7 higher passes", int_out, 1'b1);
        do_ack();
        chk("R7 nested level", lvl_out, 3'd2);
        chk("R7 nested isr", isr_out, 8'h24);
        cyc();
        send(2'd1, 8'h20);
        chk("R8 non-specific clears best", isr_out, 8'h20);
        cyc();
        chk("R7 still blocked by 5", int_out, 1'b0);
        send(2'd1, 8'h65);
        chk("R9 specific clears 5", isr_out, 8'h00);
        cyc();
        chk("R7 unblocked", int_out, 1'b1);
        do_ack();
        chk("R6 level 7", lvl_out, 3'd7);
        chk("R6 isr 7", isr_out, 8'h80);
        cyc();
        send(2'd1, 8'h20);
        chk("R8 clear 7", isr_out, 8'h00);
        send(2'd1, 8'hC3);
        irq_in = 8'h00; cyc();
        irq_in = 8'h42; cyc(); cyc();
        chk("R10 int after set-priority", int_out, 1'b1);
        do_ack();
        chk("R10 rotated winner", lvl_out, 3'd6);
        chk("R10 isr", isr_out, 8'h40);
        cyc();
        send(2'd1, 8'hA0);
        chk("R10 rotate eoi clears", isr_out, 8'h00);
        irq_in = 8'hC2; cyc();
        chk("R10 int", int_out, 1'b1);
        do_ack();
        chk("R10 pointer past 6", lvl_out, 3'd7);
        chk("R10 isr 7", isr_out, 8'h80);

        // phase B: masking and automatic retirement
        auto_eoi = 1'b1;
        do_reset();
        send(2'd0, 8'h08);
        chk("R4 mask loaded", imr_out, 8'h08);
        irq_in = 8'h08; cyc(); cyc(); cyc();
        chk("R4 masked no int", int_out, 1'b0);
        chk("R4 irr still captured", irr_out, 8'h08);
        send(2'd0, 8'h00);
        chk("R4 int one cycle later", int_out, 1'b0);
        cyc();
        chk("R4 unmasked int", int_out, 1'b1);
        do_ack();
        chk("R12 strobe", lvl_valid, 1'b1);
        chk("R12 level", lvl_out, 3'd3);
        chk("R12 no isr", isr_out, 8'h00);
        chk("R12 irr cleared", irr_out, 8'h00);
        auto_eoi = 1'b0;

        // phase C: special mask mode
        do_reset();
        irq_in = 8'h10; cyc(); cyc();
        chk("R11 int level 4", int_out, 1'b1);
        do_ack();
        chk("R11 isr 4", isr_out, 8'h10);
        cyc();
        send(2'd0, 8'h10);
        irq_in = 8'h50; cyc(); cyc(); cyc();
        chk("R11 normal blocks 6", int_out, 1'b0);
        send(2'd2, 8'h01); cyc(); cyc();
        chk("R11 enable clear ignored", int_out, 1'b0);
        send(2'd2, 8'h03); cyc(); cyc();
        chk("R11 special mask passes 6", int_out, 1'b1);
        do_ack();
        chk("R11 level 6", lvl_out, 3'd6);
        chk("R11 isr", isr_out, 8'h50);
        send(2'd2, 8'h02); cyc();

        // phase D: level capture, spurious acknowledge
        level_mode = 1'b1;
        do_reset();
        irq_in = 8'h01; cyc();
        chk("R3 irr follows", irr_out, 8'h01);
        cyc();
        chk("R3 int", int_out, 1'b1);
        irq_in = 8'h00; cyc();
        chk("R3 irr drops", irr_out, 8'h00);
        chk("R3 int still up", int_out, 1'b1);
        do_ack();
        chk("R3 spurious strobe", lvl_valid, 1'b1);
        chk("R3 spurious level", lvl_out, 3'd7);
        chk("R3 spurious no isr", isr_out, 8'h00);
        repeat (3) cyc();

        run = 0;
        fin = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!fin) begin
            checks++;
            bad++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule